// File: doc/BRIEF.md
# Network Timestamp Capture Bank

This block holds the capture registers that a multi-port network device needs for precision time protocols. Each port has a receive channel and a transmit channel. When a timing packet finishes, the channel for that port and direction stores three things at once: the free-running 64-bit time value, the packet's 16-bit sequence number and its 48-bit source identifier. Two general-purpose input pins also have channels of their own. Each of these pin channels stores only the time value, and it does so on a rising edge of its pin. Packet parsing, the frame check, the time counter and the line timing are all done elsewhere. Their results arrive here as inputs.

Every capture sets a status flag, and each flag has its own interrupt enable. A host can set a lock on any channel. While a locked channel's flag is pending, the stored record is frozen until the host clears the flag. If a channel is not locked, a newer event replaces the stored record, and a sticky overflow bit shows that the older data was lost. A read-only word gives the fixed capture latency for the current line speed, so that software can correct for it.

Top module: `ptp_stamp_bank`

## Requirements
- R1: A packet channel captures on a cycle with the end-of-frame strobe high only when both the type-match input and the frame-check-good input are also high. If either one is low, nothing is stored and no flag is set.
- R2: An end-of-frame with the octet-aligned input low never captures, even when the type-match and frame-check inputs are both good.
- R3: Channels are numbered as follows: port p receive is channel 2p, port p transmit is channel 2p+1, and GPIO g is channel 2*NPORT+g. Channel c occupies word addresses 8+4c to 11+4c. The words hold, in order: time bits 63:32, time bits 31:0, {sequence[15:0], source[47:32]}, and source[31:0]. All four words are loaded on the same clock edge. GPIO channels read zero in the last two words.
- R4: Each capture sets bit c of the status word at address 0. irq_o is high whenever some status bit is set and the matching bit of the enable word at address 1 is also set.
- R5: Bit c of the lock word at address 2 freezes channel c while its status bit is set. Once the flag is cleared, the next event loads normally. The lock bits for the receive and transmit channels of a port work independently of each other.
- R6: When an unlocked channel with a pending flag receives an event, the new record replaces the old one, the flag stays set, and bit c of the overflow word at address 3 is set. Writing 1 to an overflow bit clears it.
- R7: Writing 1 to a status bit clears it. If an event arrives on the same edge as the clear, the event wins: the flag stays set and the new record is stored, even on a locked channel.
- R8: Each GPIO input passes through two synchronizer flops and a rising-edge detector. Every rising edge causes exactly one capture, and a held-high level causes none. GPIO channels obey their lock bits in the same way as the packet channels.
- R9: Address 4 reads the capture latency in ns. The value is 30 when speed_100_i is high and 120 when it is low.
- R10: After reset, the status, enable, lock and overflow words read zero, every capture word reads zero, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now_i | input | 64 | Free-running time value |
| rx_eof_i | input | NPORT | Receive end-of-frame strobe per port |
| rx_type_ok_i | input | NPORT | Receive packet-type match |
| rx_fcs_ok_i | input | NPORT | Receive frame check good |
| rx_octet_ok_i | input | NPORT | Receive frame is a whole number of octets |
| rx_seq_i | input | NPORT*16 | Receive sequence number per port |
| rx_src_i | input | NPORT*48 | Receive source identifier per port |
| tx_eof_i | input | NPORT | Transmit end-of-frame strobe per port |
| tx_type_ok_i | input | NPORT | Transmit packet-type match |
| tx_fcs_ok_i | input | NPORT | Transmit frame check good |
| tx_octet_ok_i | input | NPORT | Transmit frame is a whole number of octets |
| tx_seq_i | input | NPORT*16 | Transmit sequence number per port |
| tx_src_i | input | NPORT*48 | Transmit source identifier per port |
| gpio_i | input | NGPIO | Asynchronous capture pins |
| speed_100_i | input | 1 | High selects the 100 Mb/s latency |
| reg_wr_i | input | 1 | Host write strobe |
| reg_addr_i | input | AW | Host word address |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Host read data, combinational from the address |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench walks a table of packet events over both ports and both directions. In that table it turns off the type match, the frame check and the octet alignment one at a time, so that a capture on good inputs can be told apart from a spurious capture on a single bad qualifier. Directed sequences then separate the three cases for a second event on a pending channel: it is held under lock, it overwrites and flags overflow when unlocked, or it wins over a same-edge clear. A GPIO level is held high after its edge, which shows whether the block captures once per edge or once per cycle. Changing the time value between events shows which cycle's time each capture stored.

// File: rtl/ptp_stamp_pkg.sv
package ptp_stamp_pkg;
  localparam int TS_W  = 64;
  localparam int SEQ_W = 16;
  localparam int SRC_W = 48;
  localparam int DW    = 32;

  // host word addresses
  localparam int A_STS   = 0;
  localparam int A_IEN   = 1;
  localparam int A_LOCK  = 2;
  localparam int A_OVF   = 3;
  localparam int A_LAT   = 4;
  localparam int CH_BASE = 8;

  typedef struct packed {
    logic [TS_W-1:0]  tstamp;
    logic [SEQ_W-1:0] seq;
    logic [SRC_W-1:0] src;
  } cap_rec_t;
endpackage

// File: rtl/ptp_gpio_edge.sv
module ptp_gpio_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/ptp_cap_chan.sv
module ptp_cap_chan
  import ptp_stamp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ev_i,
  input  cap_rec_t rec_i,
  input  logic     lock_i,
  input  logic     clr_sts_i,
  input  logic     clr_ovf_i,
  output cap_rec_t rec_o,
  output logic     sts_o,
  output logic     ovf_o
);
  cap_rec_t rec_q;
  logic     sts_q, ovf_q;
  logic     held, load_en, sts_d, ovf_d;

  always_comb begin
    // a pending flag that is not being cleared holds a locked channel
    held    = lock_i & sts_q & ~clr_sts_i;
    load_en = ev_i & ~held;
    sts_d   = ev_i | (sts_q & ~clr_sts_i);
    ovf_d   = (ev_i & sts_q & ~clr_sts_i & ~lock_i) | (ovf_q & ~clr_ovf_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q <= '0;
    end else if (load_en) begin
      rec_q <= rec_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      ovf_q <= ovf_d;
    end
  end

  assign rec_o = rec_q;
  assign sts_o = sts_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/ptp_host_regs.sv
module ptp_host_regs
  import ptp_stamp_pkg::*;
#(
  parameter int NCH = 6,
  parameter int AW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [NCH-1:0] wdata_i,
  output logic [NCH-1:0] irq_en_o,
  output logic [NCH-1:0] lock_en_o,
  output logic [NCH-1:0] sts_clr_o,
  output logic [NCH-1:0] ovf_clr_o
);
  logic [NCH-1:0] ien_q, lock_q, ien_d, lock_d;
  logic wr_ien, wr_lock;

  always_comb begin
    wr_ien    = wr_i && (addr_i == AW'(A_IEN));
    wr_lock   = wr_i && (addr_i == AW'(A_LOCK));
    ien_d     = wr_ien  ? wdata_i : ien_q;
    lock_d    = wr_lock ? wdata_i : lock_q;
    sts_clr_o = (wr_i && (addr_i == AW'(A_STS))) ? wdata_i : '0;
    ovf_clr_o = (wr_i && (addr_i == AW'(A_OVF))) ? wdata_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      lock_q <= '0;
    end else begin
      ien_q  <= ien_d;
      lock_q <= lock_d;
    end
  end

  assign irq_en_o  = ien_q;
  assign lock_en_o = lock_q;
endmodule

// File: rtl/ptp_stamp_bank.sv
module ptp_stamp_bank
  import ptp_stamp_pkg::*;
#(
  parameter int NPORT    = 2,
  parameter int NGPIO    = 2,
  parameter int AW       = 6,
  parameter int LAT_FAST = 30,
  parameter int LAT_SLOW = 120
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TS_W-1:0]        time_now_i,
  input  logic [NPORT-1:0]       rx_eof_i,
  input  logic [NPORT-1:0]       rx_type_ok_i,
  input  logic [NPORT-1:0]       rx_fcs_ok_i,
  input  logic [NPORT-1:0]       rx_octet_ok_i,
  input  logic [NPORT*SEQ_W-1:0] rx_seq_i,
  input  logic [NPORT*SRC_W-1:0] rx_src_i,
  input  logic [NPORT-1:0]       tx_eof_i,
  input  logic [NPORT-1:0]       tx_type_ok_i,
  input  logic [NPORT-1:0]       tx_fcs_ok_i,
  input  logic [NPORT-1:0]       tx_octet_ok_i,
  input  logic [NPORT*SEQ_W-1:0] tx_seq_i,
  input  logic [NPORT*SRC_W-1:0] tx_src_i,
  input  logic [NGPIO-1:0]       gpio_i,
  input  logic                   speed_100_i,
  input  logic                   reg_wr_i,
  input  logic [AW-1:0]          reg_addr_i,
  input  logic [DW-1:0]          reg_wdata_i,
  output logic [DW-1:0]          reg_rdata_o,
  output logic                   irq_o
);
  localparam int NCH  = 2*NPORT + NGPIO;
  localparam int CHIW = AW - 2;

  logic [NCH-1:0]      chan_ev, chan_sts, chan_ovf;
  logic [NCH-1:0]      irq_en, lock_en, sts_clr, ovf_clr;
  logic [NGPIO-1:0]    gpio_rise;
  logic [NCH*TS_W-1:0] chan_ts;
  cap_rec_t            rec_in [NCH];
  cap_rec_t            rec_q  [NCH];

  ptp_gpio_edge #(.N(NGPIO)) u_gpio (
    .clk(clk), .rst_n(rst_n), .pin_i(gpio_i), .rise_o(gpio_rise)
  );

  ptp_host_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i[NCH-1:0]), .irq_en_o(irq_en), .lock_en_o(lock_en),
    .sts_clr_o(sts_clr), .ovf_clr_o(ovf_clr)
  );

  // packet channels: a capture needs type match, good check and whole octets
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign chan_ev[2*p]   = rx_eof_i[p] & rx_type_ok_i[p] & rx_fcs_ok_i[p] & rx_octet_ok_i[p];
    assign chan_ev[2*p+1] = tx_eof_i[p] & tx_type_ok_i[p] & tx_fcs_ok_i[p] & tx_octet_ok_i[p];
    assign rec_in[2*p]    = cap_rec_t'({time_now_i, rx_seq_i[p*SEQ_W +: SEQ_W], rx_src_i[p*SRC_W +: SRC_W]});
    assign rec_in[2*p+1]  = cap_rec_t'({time_now_i, tx_seq_i[p*SEQ_W +: SEQ_W], tx_src_i[p*SRC_W +: SRC_W]});
  end

  for (genvar g = 0; g < NGPIO; g++) begin : g_pin
    assign chan_ev[2*NPORT+g] = gpio_rise[g];
    assign rec_in[2*NPORT+g]  = cap_rec_t'({time_now_i, {(SEQ_W+SRC_W){1'b0}}});
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    ptp_cap_chan u_chan (
      .clk(clk), .rst_n(rst_n), .ev_i(chan_ev[c]), .rec_i(rec_in[c]),
      .lock_i(lock_en[c]), .clr_sts_i(sts_clr[c]), .clr_ovf_i(ovf_clr[c]),
      .rec_o(rec_q[c]), .sts_o(chan_sts[c]), .ovf_o(chan_ovf[c])
    );
    assign chan_ts[c*TS_W +: TS_W] = rec_q[c].tstamp;
  end

  assign irq_o = |(chan_sts & irq_en);

  // host read path
  logic [AW-1:0]   ch_off;
  logic [CHIW-1:0] ch_idx;
  logic            ch_hit;
  cap_rec_t        sel_rec;

  always_comb begin
    ch_off  = reg_addr_i - AW'(CH_BASE);
    ch_idx  = ch_off[AW-1:2];
    ch_hit  = 1'b0;
    sel_rec = '0;
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr_i >= AW'(CH_BASE) && ch_idx == CHIW'(c)) begin
        ch_hit  = 1'b1;
        sel_rec = rec_q[c];
      end
    end
    reg_rdata_o = '0;
    if (ch_hit) begin
      case (ch_off[1:0])
        2'd0:    reg_rdata_o = sel_rec.tstamp[63:32];
        2'd1:    reg_rdata_o = sel_rec.tstamp[31:0];
        2'd2:    reg_rdata_o = {sel_rec.seq, sel_rec.src[47:32]};
        default: reg_rdata_o = sel_rec.src[31:0];
      endcase
    end else begin
      case (reg_addr_i)
        AW'(A_STS):  reg_rdata_o[NCH-1:0] = chan_sts;
        AW'(A_IEN):  reg_rdata_o[NCH-1:0] = irq_en;
        AW'(A_LOCK): reg_rdata_o[NCH-1:0] = lock_en;
        AW'(A_OVF):  reg_rdata_o[NCH-1:0] = chan_ovf;
        AW'(A_LAT):  reg_rdata_o = speed_100_i ? DW'(LAT_FAST) : DW'(LAT_SLOW);
        default:     reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ptp_stamp_bank_chk.sv
module ptp_stamp_bank_chk
  import ptp_stamp_pkg::*;
#(
  parameter int NPORT = 2,
  parameter int NGPIO = 2
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [NPORT-1:0]                    rx_eof_i,
  input logic [NPORT-1:0]                    rx_octet_ok_i,
  input logic [2*NPORT+NGPIO-1:0]            chan_ev,
  input logic [2*NPORT+NGPIO-1:0]            chan_sts,
  input logic [2*NPORT+NGPIO-1:0]            chan_ovf,
  input logic [2*NPORT+NGPIO-1:0]            sts_clr,
  input logic [2*NPORT+NGPIO-1:0]            lock_en,
  input logic [(2*NPORT+NGPIO)*TS_W-1:0]     chan_ts
);
  localparam int NCH = 2*NPORT + NGPIO;

  for (genvar p = 0; p < NPORT; p++) begin : g_p
    // R2: a frame that is not octet aligned never raises the receive flag
    p_no_partial_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_eof_i[p] && !rx_octet_ok_i[p] && !chan_sts[2*p]) |=> !chan_sts[2*p]);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_c
    p_flag_on_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
      chan_ev[c] |=> chan_sts[c]);
    p_rise_needs_event_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_sts[c]) |-> $past(chan_ev[c]));
    p_lock_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_en[c] && chan_sts[c] && !sts_clr[c]) |=> $stable(chan_ts[c*TS_W +: TS_W]));
    p_ovf_after_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_ovf[c]) |-> $past(chan_sts[c]));
    p_clear_only_by_host_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chan_sts[c]) |-> $past(sts_clr[c]));
  end
endmodule

bind ptp_stamp_bank ptp_stamp_bank_chk #(.NPORT(NPORT), .NGPIO(NGPIO)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_eof_i(rx_eof_i), .rx_octet_ok_i(rx_octet_ok_i),
  .chan_ev(chan_ev), .chan_sts(chan_sts), .chan_ovf(chan_ovf),
  .sts_clr(sts_clr), .lock_en(lock_en), .chan_ts(chan_ts)
);

// File: tb/tb_ptp_stamp_bank.sv
module tb_ptp_stamp_bank;
  localparam int NPORT = 2;
  localparam int NGPIO = 2;
  localparam int AW    = 6;
  localparam int NCH   = 2*NPORT + NGPIO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] time_now = '0;
  logic [NPORT-1:0] rx_eof = '0, rx_ty = '0, rx_fc = '0, rx_oc = '0;
  logic [NPORT-1:0] tx_eof = '0, tx_ty = '0, tx_fc = '0, tx_oc = '0;
  logic [NPORT*16-1:0] rx_seq = '0, tx_seq = '0;
  logic [NPORT*48-1:0] rx_src = '0, tx_src = '0;
  logic [NGPIO-1:0] gpio = '0;
  logic speed = 1'b1;
  logic wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  int total = 0;
  int bad = 0;

  logic [63:0] m_ts  [NCH];
  logic [15:0] m_seq [NCH];
  logic [47:0] m_src [NCH];

  always #10 clk = ~clk;

  ptp_stamp_bank #(.NPORT(NPORT), .NGPIO(NGPIO), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .time_now_i(time_now),
    .rx_eof_i(rx_eof), .rx_type_ok_i(rx_ty), .rx_fcs_ok_i(rx_fc), .rx_octet_ok_i(rx_oc),
    .rx_seq_i(rx_seq), .rx_src_i(rx_src),
    .tx_eof_i(tx_eof), .tx_type_ok_i(tx_ty), .tx_fcs_ok_i(tx_fc), .tx_octet_ok_i(tx_oc),
    .tx_seq_i(tx_seq), .tx_src_i(tx_src),
    .gpio_i(gpio), .speed_100_i(speed),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(int a, output logic [31:0] d);
    addr = AW'(a);
    #1;
    d = rdata;
  endtask

  task automatic wreg(int a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic drive_pkt(int p, bit tx, bit ty, bit fc, bit oc,
                           logic [63:0] t, logic [15:0] s, logic [47:0] id);
    time_now = t;
    if (tx) begin
      tx_eof[p] = 1'b1; tx_ty[p] = ty; tx_fc[p] = fc; tx_oc[p] = oc;
      tx_seq[p*16 +: 16] = s; tx_src[p*48 +: 48] = id;
    end else begin
      rx_eof[p] = 1'b1; rx_ty[p] = ty; rx_fc[p] = fc; rx_oc[p] = oc;
      rx_seq[p*16 +: 16] = s; rx_src[p*48 +: 48] = id;
    end
  endtask

  task automatic end_pkt();
    rx_eof = '0; tx_eof = '0; rx_ty = '0; rx_fc = '0; rx_oc = '0;
    tx_ty = '0; tx_fc = '0; tx_oc = '0;
  endtask

  // one-cycle packet event; returns at the negedge after the capture edge
  task automatic pkt(int p, bit tx, bit ty, bit fc, bit oc,
                     logic [63:0] t, logic [15:0] s, logic [47:0] id);
    @(negedge clk);
    drive_pkt(p, tx, ty, fc, oc, t, s, id);
    @(negedge clk);
    end_pkt();
  endtask

  task automatic model_store(int ch, logic [63:0] t, logic [15:0] s, logic [47:0] id);
    m_ts[ch] = t; m_seq[ch] = s; m_src[ch] = id;
  endtask

  task automatic chk_chan(string tag, int ch);
    logic [31:0] d;
    rd(8 + 4*ch, d);     check(tag, d, m_ts[ch][63:32]);
    rd(8 + 4*ch + 1, d); check(tag, d, m_ts[ch][31:0]);
    rd(8 + 4*ch + 2, d); check(tag, d, {m_seq[ch], m_src[ch][47:32]});
    rd(8 + 4*ch + 3, d); check(tag, d, m_src[ch][31:0]);
  endtask

  // {port, tx, type_ok, fcs_ok, octet_ok, expect_capture}
  localparam logic [5:0] VEC [8] = '{
    6'b0_0_111_1, 6'b0_0_011_0, 6'b0_0_101_0, 6'b0_0_110_0,
    6'b0_1_111_1, 6'b1_0_111_1, 6'b1_1_111_1, 6'b1_1_110_0
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    for (int c = 0; c < NCH; c++) model_store(c, '0, '0, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    @(negedge clk);
    rd(0, d); check("R10 status", d, 0);
    rd(1, d); check("R10 irq enable", d, 0);
    rd(2, d); check("R10 lock", d, 0);
    rd(3, d); check("R10 overflow", d, 0);
    check("R10 irq", irq, 0);
    chk_chan("R10 ch0 words", 0);
    chk_chan("R10 ch5 words", 5);

    // R9: latency by speed
    speed = 1'b1; rd(4, d); check("R9 latency fast", d, 30);
    speed = 1'b0; rd(4, d); check("R9 latency slow", d, 120);
    speed = 1'b1;

    // R1 R2 R3 R4: vector table
    for (int i = 0; i < 8; i++) begin
      logic [5:0] v;
      logic [63:0] t;
      logic [15:0] s;
      logic [47:0] id;
      int ch;
      v  = VEC[i];
      t  = 64'h0123_4567_0000_0000 + 64'(i) * 64'h0000_0001_0000_1111;
      s  = 16'h0100 + 16'(i);
      id = 48'hA0B0_C0D0_0000 + 48'(i);
      ch = 2*int'(v[5]) + int'(v[4]);
      pkt(int'(v[5]), v[4], v[3], v[2], v[1], t, s, id);
      if (v[0]) model_store(ch, t, s, id);
      rd(0, d);
      check($sformatf("R1 R2 R4 vec%0d status", i), d, v[0] ? (32'd1 << ch) : 32'd0);
      chk_chan($sformatf("R3 vec%0d words", i), ch);
      wreg(0, 32'hFFFF_FFFF);
    end

    // R4: interrupt gating by enable
    wreg(1, 32'h1);
    pkt(0, 0, 1, 1, 1, 64'h11, 16'h11, 48'h11);
    model_store(0, 64'h11, 16'h11, 48'h11);
    check("R4 irq enabled", irq, 1);
    wreg(1, 32'h0);
    check("R4 irq masked", irq, 0);
    rd(0, d); check("R4 status kept while masked", d, 32'h1);
    wreg(0, 32'h1);
    rd(0, d); check("R7 write-1 clears", d, 0);

    // R5: lock receive of port 0 only
    wreg(2, 32'h1);
    pkt(0, 0, 1, 1, 1, 64'h2000_0000_0000_00A1, 16'hA1, 48'hA1);
    model_store(0, 64'h2000_0000_0000_00A1, 16'hA1, 48'hA1);
    pkt(0, 0, 1, 1, 1, 64'h2000_0000_0000_00B2, 16'hB2, 48'hB2);
    chk_chan("R5 locked hold", 0);
    // R6: transmit of port 0 unlocked, second event overwrites
    pkt(0, 1, 1, 1, 1, 64'h31, 16'h31, 48'h31);
    pkt(0, 1, 1, 1, 1, 64'h32, 16'h32, 48'h32);
    model_store(1, 64'h32, 16'h32, 48'h32);
    chk_chan("R6 unlocked overwrite", 1);
    rd(0, d); check("R6 flags stay set", d, 32'h3);
    rd(3, d); check("R6 overflow bit", d, 32'h2);
    wreg(3, 32'hFFFF_FFFF);
    rd(3, d); check("R6 overflow cleared", d, 0);
    // R5: after clear the locked channel loads again
    wreg(0, 32'h3);
    pkt(0, 0, 1, 1, 1, 64'h2000_0000_0000_00C3, 16'hC3, 48'hC3);
    model_store(0, 64'h2000_0000_0000_00C3, 16'hC3, 48'hC3);
    chk_chan("R5 reload after clear", 0);

    // R7: event on the same edge as the clear wins (locked channel)
    @(negedge clk);
    drive_pkt(0, 0, 1, 1, 1, 64'h2000_0000_0000_00D4, 16'hD4, 48'hD4);
    wr = 1'b1; addr = AW'(0); wdata = 32'h1;
    @(negedge clk);
    end_pkt();
    wr = 1'b0;
    model_store(0, 64'h2000_0000_0000_00D4, 16'hD4, 48'hD4);
    rd(0, d); check("R7 flag survives clear", d, 32'h1);
    chk_chan("R7 new data stored", 0);
    wreg(0, 32'hFFFF_FFFF);
    wreg(2, 32'h0);

    // R8: GPIO edge capture, one per edge
    @(negedge clk);
    time_now = 64'h4444_0000_0000_0001;
    gpio[0] = 1'b1;
    repeat (4) @(negedge clk);
    model_store(4, 64'h4444_0000_0000_0001, '0, '0);
    rd(0, d); check("R8 gpio0 flag", d, 32'h10);
    chk_chan("R8 gpio0 time", 4);
    wreg(0, 32'h10);
    repeat (5) @(negedge clk);
    rd(0, d); check("R8 held level no capture", d, 0);
    // GPIO lock
    wreg(2, 32'h10);
    gpio[0] = 1'b0;
    repeat (3) @(negedge clk);
    time_now = 64'h4444_0000_0000_0002;
    gpio[0] = 1'b1;
    repeat (4) @(negedge clk);
    model_store(4, 64'h4444_0000_0000_0002, '0, '0);
    chk_chan("R8 gpio0 second edge", 4);
    gpio[0] = 1'b0;
    repeat (3) @(negedge clk);
    time_now = 64'h4444_0000_0000_0003;
    gpio[0] = 1'b1;
    repeat (4) @(negedge clk);
    chk_chan("R8 gpio0 lock holds", 4);
    rd(0, d); check("R8 gpio0 flag pending", d, 32'h10);
    // second pin unlocked
    time_now = 64'h5555_0000_0000_0004;
    gpio[1] = 1'b1;
    repeat (4) @(negedge clk);
    model_store(5, 64'h5555_0000_0000_0004, '0, '0);
    rd(0, d); check("R8 gpio1 flag", d, 32'h30);
    chk_chan("R8 gpio1 time", 5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule